// File: doc/BRIEF.md
# Serial Flash Page-Program Controller

This block takes a burst of data bytes from a parallel user port and holds them in an internal page buffer. It then programs them into an external serial NOR flash over a mode-0 SPI link. The user loads bytes with a byte strobe, presents a start address, and pulses a write strobe with the write-enable input high. The controller first reads the flash status register and checks the block-protect field against the target address. It then sends write-enable and page-program, streams the buffered bytes after the address, and polls the status register until the flash reports that programming is complete.

A busy output covers the whole command. A write aimed at a protected region is abandoned and signalled by a refusal pulse of exactly two cycles. The flash itself wraps a burst that runs past the end of a 256-byte page back to offset zero of the same page, so the controller sends only the start address and never splits a burst. If the strobes are still held when busy falls, the block takes them as a new command.

Top module: `flash_page_writer`

## Requirements
- R1: While busy is low, each rising clock edge with `load_byte` high appends `load_data` to the page buffer. The buffer holds at most PAGE (256) bytes; when more are loaded, the oldest are dropped, so the last 256 remain in load order.
- R2: `write_strobe` and `start_addr` are registered on the same rising edge. When `write_enable` is also high at that edge and the block is idle, `busy` is high from that edge on.
- R3: A strobe taken with `write_enable` low does nothing: busy stays low, chip select stays high, and the buffer contents are kept for a later write.
- R4: An accepted write sends, in order, read-status (0x05 plus one read byte), write-enable (0x06) in its own chip-select frame, and page-program (0x02). The page-program command is followed by the start address, most significant byte first, and then the buffered bytes in load order, all within one chip-select low period.
- R5: Only the start address is sent. Bytes beyond the end of the 256-byte page land at offset 0x00 of the same page, not in the next page.
- R6: After page-program the block repeats read-status (0x05) until status bit 0 (write in progress) reads 0. Busy stays high until then and falls one cycle after that last status frame ends.
- R7: Status bits [4:2] form a protect count n. When n is nonzero, the addresses whose top three bits are at least 8-n are protected. A write to a protected address sends neither 0x06 nor 0x02; busy falls, and `wr_refused` is high for exactly two clock cycles while busy is low.
- R8: If `write_strobe` and `write_enable` are still high when busy falls, the next rising edge accepts them as a new write.
- R9: The SPI link is mode 0. The serial clock runs at half the input clock, idles low, and toggles only while chip select is low. Chip select is low only while busy is high.
- R10: Parameter ADDR_W selects a 24-bit or 32-bit start address, which is sent as 3 or 4 address bytes respectively.
- R11: The buffer is emptied when a write finishes or is refused, so a following write with no new bytes programs no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_byte | input | 1 | Append `load_data` to the page buffer |
| load_data | input | 8 | Data byte to buffer |
| write_enable | input | 1 | Qualifies the write strobe |
| write_strobe | input | 1 | Start a page program |
| start_addr | input | ADDR_W | Flash start address, valid with the strobe |
| busy | output | 1 | Command in progress |
| wr_refused | output | 1 | Two-cycle pulse: write to a protected region cancelled |
| flash_sck | output | 1 | SPI serial clock |
| flash_cs_n | output | 1 | SPI chip select, active low |
| flash_mosi | output | 1 | SPI data to flash |
| flash_miso | input | 1 | SPI data from flash |

## Verification
Busy is due one clock after the accepting edge, so the bench drives inputs on falling edges and reads busy at the next falling edge. The refusal pulse and the two-cycle pulse length are measured by a monitor that runs every clock. Chip-select, serial-clock idle and write-in-progress coverage rules are also compared every clock against a behavioural SPI flash model. Memory contents, the command sequence and the address the flash decoded are compared only once busy has fallen, since the flash state they reflect is final at that point.

// File: rtl/fpw_pkg.sv
`timescale 1ns/1ps
package fpw_pkg;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_ARM    = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RS_CMD, ST_RS_DAT, ST_CHECK, ST_REFUSE, ST_ARM, ST_GAP1,
    ST_PP_CMD, ST_PP_ADR, ST_PP_DAT, ST_GAP2, ST_PL_CMD, ST_PL_DAT, ST_PL_CHK
  } seq_st_e;

  // protect count n locks the top n eighths of the address space
  function automatic logic region_locked(logic [2:0] n, logic [2:0] top3);
    return (n != 3'd0) && ({1'b0, top3} >= (4'd8 - {1'b0, n}));
  endfunction

  // storage slot of the idx-th oldest byte in a circular buffer
  function automatic int slot_of(int wp, int cnt, int idx, int depth);
    return (wp + depth - cnt + idx) % depth;
  endfunction

  // idx-th address byte, most significant first
  function automatic logic [7:0] addr_byte(logic [31:0] a, int nbytes, int idx);
    return 8'(a >> (8 * (nbytes - 1 - idx)));
  endfunction
endpackage

// File: rtl/fpw_page_buf.sv
`timescale 1ns/1ps
module fpw_page_buf #(
  parameter int DEPTH = 256,            // power of two
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          clear,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count
);
  import fpw_pkg::*;

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] wp;
  logic [CW-1:0] cnt;
  logic          full;

  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else if (clear) begin
      wp  <= '0;
      cnt <= '0;
    end else if (push) begin
      wp <= wp + 1'b1;
      if (!full) cnt <= cnt + 1'b1;
    end
  end

  assign rd_data = mem[IW'(slot_of(int'(wp), int'(cnt), int'(rd_idx), DEPTH))];

  p_count_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && full) |=> (cnt == CW'(DEPTH)));
  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/fpw_spi_shift.sv
`timescale 1ns/1ps
module fpw_spi_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       active,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  logic       act_q, sck_q, done_q;
  logic [7:0] sh, rx_q;
  logic [2:0] bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      sh <= '0; rx_q <= '0; bitn <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q <= 1'b1;
          sh    <= tx;
          bitn  <= '0;
        end
      end else if (!sck_q) begin
        sck_q <= 1'b1;                      // rising edge: both sides sample
        rx_q  <= {rx_q[6:0], miso};
      end else begin
        sck_q <= 1'b0;                      // falling edge: next bit out
        if (bitn == 3'd7) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bitn <= bitn + 1'b1;
          sh   <= {sh[6:0], 1'b0};
        end
      end
    end
  end

  assign active = act_q;
  assign done   = done_q;
  assign rx     = rx_q;
  assign sck    = sck_q;
  assign mosi   = sh[7];

  p_sck_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck_q);
  p_sck_half_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |=> !sck_q);
  p_mosi_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && sck_q) |-> $stable(sh));
endmodule

// File: rtl/fpw_seq.sv
`timescale 1ns/1ps
module fpw_seq #(
  parameter int AW    = 24,
  parameter int DEPTH = 256,
  localparam int AB = AW / 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          write,
  input  logic          wren,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] buf_cnt,
  input  logic [7:0]    buf_rd,
  output logic [IW-1:0] buf_idx,
  output logic          buf_clear,
  output logic          busy,
  output logic          refused,
  output logic          cs_n,
  output logic          sh_start,
  output logic [7:0]    sh_tx,
  input  logic          sh_done,
  input  logic [7:0]    sh_rx
);
  import fpw_pkg::*;

  seq_st_e       st;
  logic [AW-1:0] addr_q;
  logic [7:0]    stat_q;
  logic [CW-1:0] idx;
  logic          busy_q, ref_q, ref_step, cs_q, issued, need_tx;

  // named events for assertions
  logic accept_ev, cancel_ev, finish_ev, locked;
  assign accept_ev = (st == ST_IDLE) && write && wren;
  assign locked    = region_locked(stat_q[4:2], addr_q[AW-1 -: 3]);
  assign cancel_ev = (st == ST_CHECK) && locked;
  assign finish_ev = (st == ST_PL_CHK) && !stat_q[0];

  always_comb begin
    need_tx = 1'b1;
    sh_tx   = 8'h00;
    case (st)
      ST_RS_CMD, ST_PL_CMD: sh_tx = OP_STATUS;
      ST_RS_DAT, ST_PL_DAT: sh_tx = 8'h00;
      ST_ARM:               sh_tx = OP_ARM;
      ST_PP_CMD:            sh_tx = OP_PROG;
      ST_PP_ADR:            sh_tx = addr_byte(32'(addr_q), AB, int'(idx));
      ST_PP_DAT:            sh_tx = buf_rd;
      default:              need_tx = 1'b0;
    endcase
  end

  assign sh_start  = need_tx && !issued;
  assign buf_idx   = idx[IW-1:0];
  assign buf_clear = finish_ev || ((st == ST_REFUSE) && ref_step);
  assign busy      = busy_q;
  assign refused   = ref_q;
  assign cs_n      = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; addr_q <= '0; stat_q <= '0; idx <= '0;
      busy_q <= 1'b0; ref_q <= 1'b0; ref_step <= 1'b0; cs_q <= 1'b1; issued <= 1'b0;
    end else begin
      if (sh_start) issued <= 1'b1;
      if (sh_done)  issued <= 1'b0;
      case (st)
        ST_IDLE: if (accept_ev) begin
          addr_q <= addr; busy_q <= 1'b1; cs_q <= 1'b0; st <= ST_RS_CMD;
        end
        ST_RS_CMD: if (sh_done) st <= ST_RS_DAT;
        ST_RS_DAT: if (sh_done) begin
          stat_q <= sh_rx; cs_q <= 1'b1; st <= ST_CHECK;
        end
        ST_CHECK: if (locked) begin
          busy_q <= 1'b0; ref_q <= 1'b1; ref_step <= 1'b0; st <= ST_REFUSE;
        end else begin
          cs_q <= 1'b0; st <= ST_ARM;
        end
        ST_REFUSE: if (!ref_step) ref_step <= 1'b1;
                   else begin ref_q <= 1'b0; st <= ST_IDLE; end
        ST_ARM: if (sh_done) begin cs_q <= 1'b1; st <= ST_GAP1; end
        ST_GAP1: begin cs_q <= 1'b0; st <= ST_PP_CMD; end
        ST_PP_CMD: if (sh_done) begin idx <= '0; st <= ST_PP_ADR; end
        ST_PP_ADR: if (sh_done) begin
          if (idx == CW'(AB - 1)) begin
            idx <= '0;
            if (buf_cnt == '0) begin cs_q <= 1'b1; st <= ST_GAP2; end
            else st <= ST_PP_DAT;
          end else idx <= idx + 1'b1;
        end
        ST_PP_DAT: if (sh_done) begin
          if (idx == buf_cnt - 1'b1) begin cs_q <= 1'b1; st <= ST_GAP2; end
          idx <= idx + 1'b1;
        end
        ST_GAP2: begin cs_q <= 1'b0; st <= ST_PL_CMD; end
        ST_PL_CMD: if (sh_done) st <= ST_PL_DAT;
        ST_PL_DAT: if (sh_done) begin
          stat_q <= sh_rx; cs_q <= 1'b1; st <= ST_PL_CHK;
        end
        ST_PL_CHK: if (stat_q[0]) begin cs_q <= 1'b0; st <= ST_PL_CMD; end
                   else begin busy_q <= 1'b0; st <= ST_IDLE; end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> busy_q);
  p_wren_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && !wren) |=> (!busy_q && cs_q));
  p_cs_inside_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> busy_q);
  p_busy_until_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !ref_q) |-> $past(finish_ev));
  p_refuse_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_q) |=> ref_q);
  p_refuse_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q && $past(ref_q)) |=> !ref_q);
  p_refuse_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q |-> (!busy_q && cs_q));
  p_cancel_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_ev |=> $rose(ref_q));
  p_status_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP1) |-> $stable(stat_q));
endmodule

// File: rtl/flash_page_writer.sv
`timescale 1ns/1ps
module flash_page_writer #(
  parameter int ADDR_W = 24,            // 24 or 32
  parameter int PAGE   = 256,
  localparam int IW = $clog2(PAGE),
  localparam int CW = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_byte,
  input  logic [7:0]        load_data,
  input  logic              write_enable,
  input  logic              write_strobe,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              wr_refused,
  output logic              flash_sck,
  output logic              flash_cs_n,
  output logic              flash_mosi,
  input  logic              flash_miso
);
  logic          push, clr, sh_start, sh_done, sh_active;
  logic [7:0]    rd_data, sh_tx, sh_rx;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] cnt;

  assign push = load_byte && !busy;

  fpw_page_buf #(.DEPTH(PAGE)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .din(load_data), .clear(clr),
    .rd_idx(rd_idx), .rd_data(rd_data), .count(cnt)
  );

  fpw_seq #(.AW(ADDR_W), .DEPTH(PAGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .write(write_strobe), .wren(write_enable),
    .addr(start_addr), .buf_cnt(cnt), .buf_rd(rd_data), .buf_idx(rd_idx),
    .buf_clear(clr), .busy(busy), .refused(wr_refused), .cs_n(flash_cs_n),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx)
  );

  fpw_spi_shift u_spi (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .active(sh_active),
    .done(sh_done), .rx(sh_rx), .sck(flash_sck), .mosi(flash_mosi), .miso(flash_miso)
  );

  p_no_shift_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sh_active);
endmodule

// File: tb/test_flash_page_writer.sv
`timescale 1ns/1ps
module tb_flash #(parameter int ABYTES = 3) (
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  input  logic [2:0] bp,
  input  int         polls
);
  logic [7:0] mem [int unsigned];
  byte unsigned cmds[$];
  int unsigned pp_addr;
  int data_cnt, wip_left, bitc, bytec;
  logic wel, sck_d, cs_d;
  logic [7:0] sh, osr, cmd;

  initial begin
    miso = 1'b0; wel = 1'b0; wip_left = 0; bitc = 0; bytec = 0;
    sck_d = 1'b0; cs_d = 1'b1; sh = '0; osr = '0; cmd = '0; pp_addr = 0; data_cnt = 0;
  end

  function automatic logic [7:0] rd(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  always @(sck or cs_n) begin
    if (cs_d && !cs_n) begin bitc = 0; bytec = 0; end
    if (!cs_d && cs_n) begin
      if (cmd == 8'h06 && bytec == 1) wel = 1'b1;
      if (cmd == 8'h02 && wel) begin wip_left = polls; wel = 1'b0; end
    end
    if (!cs_n && !sck_d && sck) begin
      sh = {sh[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (bytec == 0) begin
          cmd = sh;
          cmds.push_back(sh);
          if (sh == 8'h05) begin
            osr = {3'b000, bp, wel, (wip_left > 0)};
            if (wip_left > 0) wip_left--;
          end
          if (sh == 8'h02) begin pp_addr = 0; data_cnt = 0; end
        end else if (cmd == 8'h02) begin
          if (bytec <= ABYTES) pp_addr = (pp_addr << 8) | sh;
          else begin
            if (wel) mem[(pp_addr & ~32'hFF) | ((pp_addr + data_cnt) & 32'hFF)] = sh;
            data_cnt++;
          end
        end
        bytec++;
      end
    end
    if (!cs_n && sck_d && !sck) begin
      miso = osr[7];
      osr = {osr[6:0], 1'b0};
    end
    sck_d = sck;
    cs_d = cs_n;
  end
endmodule

module test_flash_page_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 0, wen = 0, wgo = 0;
  logic [7:0] ldat = 0;
  logic [23:0] addr = 0;
  logic busy, refused, sck, cs_n, mosi, miso;
  logic [2:0] bp = 0;
  int polls = 0;
  logic ld2 = 0, wen2 = 0, wgo2 = 0;
  logic [7:0] ldat2 = 0;
  logic [31:0] addr2 = 0;
  logic busy2, refused2, sck2, cs2_n, mosi2, miso2;
  int checks = 0, errors = 0, ref_run = 0, ref_pulses = 0;

  always #4 clk = ~clk;

  flash_page_writer i_flash_page_writer (
    .clk(clk), .rst_n(rst_n), .load_byte(ld), .load_data(ldat), .write_enable(wen),
    .write_strobe(wgo), .start_addr(addr), .busy(busy), .wr_refused(refused),
    .flash_sck(sck), .flash_cs_n(cs_n), .flash_mosi(mosi), .flash_miso(miso));
  tb_flash #(.ABYTES(3)) f1 (.sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso), .bp(bp), .polls(polls));

  flash_page_writer #(.ADDR_W(32)) i_wide (
    .clk(clk), .rst_n(rst_n), .load_byte(ld2), .load_data(ldat2), .write_enable(wen2),
    .write_strobe(wgo2), .start_addr(addr2), .busy(busy2), .wr_refused(refused2),
    .flash_sck(sck2), .flash_cs_n(cs2_n), .flash_mosi(mosi2), .flash_miso(miso2));
  tb_flash #(.ABYTES(4)) f2 (.sck(sck2), .cs_n(cs2_n), .mosi(mosi2), .miso(miso2), .bp(3'd0), .polls(2));

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int count_op(byte unsigned v);
    int n = 0;
    foreach (f1.cmds[i]) if (f1.cmds[i] == v) n++;
    return n;
  endfunction

  // every-clock reference rules
  always @(negedge clk) if (rst_n) begin
    check(!(!cs_n && !busy), "R9", "chip select low while idle", cs_n, 1);
    check(!(cs_n && sck), "R9", "serial clock outside frame", sck, 0);
    check(!(f1.wip_left > 0 && !busy), "R6", "busy low while flash programming", busy, 1);
    check(!(refused && busy), "R7", "refusal during busy", busy, 0);
    if (refused) ref_run++;
    else if (ref_run != 0) begin
      check(ref_run == 2, "R7", "refusal pulse length", ref_run, 2);
      ref_pulses++;
      ref_run = 0;
    end
  end

  task automatic load(byte unsigned q[$]);
    foreach (q[i]) begin ld = 1; ldat = q[i]; @(negedge clk); end
    ld = 0;
  endtask

  task automatic strobe(logic [23:0] a, logic en);
    addr = a; wen = en; wgo = 1; @(negedge clk); wgo = 0; wen = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    byte unsigned q[$];
    int n0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && refused == 0, "R2", "reset busy/refused", {busy, refused}, 0);
    check(cs_n == 1 && sck == 0, "R9", "reset SPI idle", {cs_n, sck}, 2);

    // basic write, three busy polls
    polls = 3;
    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    load(q);
    n0 = f1.cmds.size();
    strobe(24'h001000, 1);
    check(busy == 1, "R2", "busy after accept", busy, 1);
    wait_idle();
    check(f1.cmds.size() - n0 == 7, "R4", "command count", f1.cmds.size() - n0, 7);
    check(f1.cmds[n0] == 8'h05 && f1.cmds[n0+1] == 8'h06 && f1.cmds[n0+2] == 8'h02,
          "R4", "command order", {f1.cmds[n0], f1.cmds[n0+1], f1.cmds[n0+2]}, 24'h050602);
    check(f1.cmds[n0+6] == 8'h05 && f1.wip_left == 0, "R6", "polled until clear", f1.wip_left, 0);
    check(f1.pp_addr == 32'h1000 && f1.data_cnt == 4, "R4", "address and data count", f1.pp_addr, 32'h1000);
    check({f1.rd(32'h1000), f1.rd(32'h1003)} == 16'h1144, "R1", "programmed bytes",
          {f1.rd(32'h1000), f1.rd(32'h1003)}, 16'h1144);

    // in-page wraparound
    polls = 1;
    q = {};
    for (int i = 0; i < 32; i++) q.push_back(8'(8'h40 + i));
    load(q);
    strobe(24'h0020F0, 1);
    wait_idle();
    check(f1.pp_addr == 32'h20F0, "R5", "only start address sent", f1.pp_addr, 32'h20F0);
    check(f1.rd(32'h20FF) == 8'h4F, "R5", "page end byte", f1.rd(32'h20FF), 8'h4F);
    check(f1.rd(32'h2000) == 8'h50 && f1.rd(32'h200F) == 8'h5F, "R5", "wrapped bytes",
          {f1.rd(32'h2000), f1.rd(32'h200F)}, 16'h505F);
    check(f1.rd(32'h2100) == 8'hFF, "R5", "next page untouched", f1.rd(32'h2100), 8'hFF);

    // more than a page loaded: last 256 kept
    q = {};
    for (int i = 0; i < 260; i++) q.push_back(8'(i));
    load(q);
    strobe(24'h003000, 1);
    wait_idle();
    check(f1.data_cnt == 256, "R1", "data count capped", f1.data_cnt, 256);
    check(f1.rd(32'h3000) == 8'h04 && f1.rd(32'h30FF) == 8'h03, "R1", "oldest dropped",
          {f1.rd(32'h3000), f1.rd(32'h30FF)}, 16'h0403);

    // buffer emptied after a write
    strobe(24'h004000, 1);
    wait_idle();
    check(f1.data_cnt == 0 && f1.rd(32'h4000) == 8'hFF, "R11", "no stale data", f1.data_cnt, 0);

    // write_enable low: nothing happens, buffer kept
    q = '{8'h5A, 8'hC3};
    load(q);
    n0 = f1.cmds.size();
    strobe(24'h005000, 0);
    check(busy == 0, "R3", "busy stays low", busy, 0);
    for (int i = 0; i < 40; i++) begin
      if (busy || !cs_n) check(0, "R3", "activity after ignored strobe", {busy, cs_n}, 1);
      @(negedge clk);
    end
    check(f1.cmds.size() == n0, "R3", "no SPI command", f1.cmds.size(), n0);
    strobe(24'h005000, 1);
    wait_idle();
    check(f1.data_cnt == 2 && f1.rd(32'h5001) == 8'hC3, "R3", "buffer kept", f1.data_cnt, 2);

    // protected region
    bp = 3'd2;
    q = '{8'hAA, 8'hBB};
    load(q);
    n0 = f1.cmds.size();
    p0 = ref_pulses;
    strobe(24'hE00000, 1);
    check(busy == 1, "R2", "busy before protect check", busy, 1);
    wait_idle();
    repeat (4) @(negedge clk);
    check(f1.cmds.size() - n0 == 1 && f1.cmds[n0] == 8'h05, "R7", "only status read",
          f1.cmds.size() - n0, 1);
    check(ref_pulses == p0 + 1, "R7", "one refusal pulse", ref_pulses - p0, 1);
    check(f1.rd(32'hE00000) == 8'hFF, "R7", "protected memory untouched", f1.rd(32'hE00000), 8'hFF);
    strobe(24'hC00000, 1);
    wait_idle();
    repeat (4) @(negedge clk);
    check(ref_pulses == p0 + 2, "R7", "boundary address refused", ref_pulses - p0, 2);
    q = '{8'hCC};
    load(q);
    strobe(24'hA00000, 1);
    wait_idle();
    check(f1.rd(32'hA00000) == 8'hCC && f1.data_cnt == 1, "R7", "unprotected write proceeds",
          f1.rd(32'hA00000), 8'hCC);
    check(ref_pulses == p0 + 2, "R11", "no extra refusal", ref_pulses - p0, 2);
    bp = 3'd0;

    // strobes held through the fall of busy
    polls = 1;
    q = '{8'h01, 8'h02};
    load(q);
    p0 = count_op(8'h02);
    addr = 24'h006000; wen = 1; wgo = 1;
    @(negedge clk);
    check(busy == 1, "R8", "first write accepted", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(busy == 1, "R8", "re-accepted after busy fell", busy, 1);
    wgo = 0; wen = 0;
    wait_idle();
    check(count_op(8'h02) == p0 + 2, "R8", "two program commands", count_op(8'h02) - p0, 2);
    check(f1.rd(32'h6000) == 8'h01 && f1.data_cnt == 0, "R8", "second write empty", f1.data_cnt, 0);

    // 32-bit address build
    ld2 = 1; ldat2 = 8'h77; @(negedge clk);
    ldat2 = 8'h88; @(negedge clk);
    ld2 = 0;
    addr2 = 32'h12345600; wen2 = 1; wgo2 = 1; @(negedge clk); wgo2 = 0; wen2 = 0;
    check(busy2 == 1, "R10", "wide build busy", busy2, 1);
    for (int i = 0; i < 20000 && busy2; i++) @(negedge clk);
    check(f2.pp_addr == 32'h12345600, "R10", "four address bytes", f2.pp_addr, 32'h12345600);
    check(f2.rd(32'h12345600) == 8'h77 && f2.rd(32'h12345601) == 8'h88, "R10", "wide data",
          {f2.rd(32'h12345600), f2.rd(32'h12345601)}, 16'h7788);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule